// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block holds two 24-bit memory pointers, a primary and a shadow. Each pointer is stored as three 8-bit bytes: low, high and page. A small control byte says which pointer is active and what happens to it after each pointer-based data access. The active pointer can stay as it is, step up by one, or step down by one. Carries and borrows run across all three bytes. The control byte can also make the unit swap to the other pointer after every access. This lets a core move a block of data between two regions with no instructions spent on swapping or stepping pointers.

A core reaches the unit through byte-wide register writes and a separate combinational read port. It pulses `acc_stb` once for every data access that uses the pointer. The 24-bit address of the active pointer is always present on `addr_out`.

The pointer select is a two-state machine with states `SEL_PRI` (primary active) and `SEL_SHD` (shadow active). It has three transitions:
- **ctl_load**: a write to the control byte moves the machine to the state given by bit 0 of the written data.
- **auto_swap**: an access with toggle enabled, in a cycle with no register write, moves the machine to the other state.
- **hold**: in every other cycle the machine stays where it is.

Top module: `dptr_unit`

## Requirements
- R1: After reset, both pointers are 0x000000, the control byte reads 0x00, the primary pointer is active and `addr_out` is 0.
- R2: Register addresses 0, 1 and 2 are the low, high and page bytes of the currently active pointer. A write to one of them changes that byte only. It never changes the inactive pointer. The byte reads back on `reg_rdata`.
- R3: Register address 3 is the control byte, with these bits:
  - bit 0: pointer select (0 = primary, 1 = shadow).
  - bits 2:1: primary step mode.
  - bits 4:3: shadow step mode.
  - bit 5: toggle enable.
  - bits 7:6: always read 0.
- R4: `addr_out` always equals {page, high, low} of the active pointer.
- R5: Step mode 01 adds one to the active pointer after an access. The carry runs from the low byte through the high byte into the page byte.
- R6: Step mode 10 subtracts one from the active pointer after an access. The borrow runs up through all three bytes in the same way.
- R7: Stepping wraps modulo 2^24: 0xFFFFFF plus one gives 0x000000, and 0x000000 minus one gives 0xFFFFFF.
- R8: Step modes 00 and 11 leave the pointer unchanged after an access.
- R9: When toggle is enabled, each access first steps the pointer that was active, using that pointer's own mode. The select then flips to the other pointer.
- R10: In a cycle with any register write, `acc_stb` has no effect: no step and no toggle.
- R11: An access never changes the inactive pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_waddr | input | 2 | Write register address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 2 | Read register address |
| reg_rdata | output | 8 | Read data (combinational) |
| acc_stb | input | 1 | Pointer-based data access strobe |
| addr_out | output | 24 | Address held by the active pointer |

## Verification
The hardest behaviour to reach from the ports is the case where carry or borrow crosses both byte boundaries. It has to happen while toggle is on and the two pointers use different modes, because a mistake there shows up only in the page byte of the pointer that is no longer active. A second hard case is a register write landing in the same cycle as an access. The stimulus handles both in two ways:
- Directed runs load pointers at 0xFFFFFF, 0x00FFFF, 0x010000 and 0x000000, then step them with toggle on and off.
- A seeded random phase writes the control byte often enough that mode, toggle and select change many times. It also places accesses in cycles that carry register writes.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

    // Step mode codes (R3, R5, R6, R8)
    typedef enum logic [1:0] {
        MOD_HOLD = 2'b00,
        MOD_INC  = 2'b01,
        MOD_DEC  = 2'b10,
        MOD_RSVD = 2'b11
    } mod_e;

    // Pointer select states
    typedef enum logic {
        SEL_PRI = 1'b0,
        SEL_SHD = 1'b1
    } sel_e;

    // Register address map
    localparam logic [1:0] RA_LO  = 2'd0;
    localparam logic [1:0] RA_HI  = 2'd1;
    localparam logic [1:0] RA_PG  = 2'd2;
    localparam logic [1:0] RA_CTL = 2'd3;

endpackage

// File: rtl/dptr_bank.sv
module dptr_bank
    import dptr_pkg::*;
#(
    parameter int BW = 8,
    parameter int NB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             wr_en,
    input  logic [1:0]       wr_idx,
    input  logic [BW-1:0]    wr_data,
    input  logic             step_en,
    input  mod_e             mode,
    output logic [NB*BW-1:0] ptr
);
    localparam int AW = NB * BW;
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (active && wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (int'(wr_idx) == b) ptr_d[b*BW +: BW] = wr_data;
            end
        end else if (active && step_en) begin
            unique case (mode)
                MOD_INC:  ptr_d = ptr_q + ONE;
                MOD_DEC:  ptr_d = ptr_q - ONE;
                MOD_HOLD,
                MOD_RSVD: ptr_d = ptr_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R11
    inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(ptr_q));
    // R5
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step_en && !wr_en && mode == MOD_INC) |=> ptr_q == $past(ptr_q) + ONE);
    // R6
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step_en && !wr_en && mode == MOD_DEC) |=> ptr_q == $past(ptr_q) - ONE);
    // R8
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (mode == MOD_HOLD || mode == MOD_RSVD)) |=> $stable(ptr_q));

endmodule

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
    import dptr_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [BW-1:0] ctl_wdata,
    input  logic          acc_go,
    output sel_e          sel,
    output mod_e          mode_pri,
    output mod_e          mode_shd,
    output logic          tog_en,
    output logic [BW-1:0] ctl_rdata
);
    sel_e state_q, state_d;
    mod_e mp_q, ms_q;
    logic tg_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEL_PRI;
        else        state_q <= state_d;
    end

    // next state: ctl_load, auto_swap, hold
    always_comb begin
        state_d = state_q;
        if (ctl_we) begin
            state_d = sel_e'(ctl_wdata[0]);
        end else if (acc_go && tg_q) begin
            unique case (state_q)
                SEL_PRI: state_d = SEL_SHD;
                SEL_SHD: state_d = SEL_PRI;
            endcase
        end
    end

    // mode and toggle fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mp_q <= MOD_HOLD;
            ms_q <= MOD_HOLD;
            tg_q <= 1'b0;
        end else if (ctl_we) begin
            mp_q <= mod_e'(ctl_wdata[2:1]);
            ms_q <= mod_e'(ctl_wdata[4:3]);
            tg_q <= ctl_wdata[5];
        end
    end

    // outputs
    always_comb begin
        sel       = state_q;
        mode_pri  = mp_q;
        mode_shd  = ms_q;
        tog_en    = tg_q;
        ctl_rdata = '0;
        ctl_rdata[0]   = state_q;
        ctl_rdata[2:1] = mp_q;
        ctl_rdata[4:3] = ms_q;
        ctl_rdata[5]   = tg_q;
    end

    // R9
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && !ctl_we && tg_q) |=> state_q != $past(state_q));
    // R10
    idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_we && !(acc_go && tg_q)) |=> $stable(state_q));

endmodule

// File: rtl/dptr_unit.sv
module dptr_unit
    import dptr_pkg::*;
#(
    parameter int BW = 8,
    parameter int NB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_waddr,
    input  logic [BW-1:0]    reg_wdata,
    input  logic [1:0]       reg_raddr,
    output logic [BW-1:0]    reg_rdata,
    input  logic             acc_stb,
    output logic [NB*BW-1:0] addr_out
);
    localparam int AW = NB * BW;
    localparam int NP = 2;

    sel_e          sel;
    mod_e          mode_pri, mode_shd;
    logic          tog_en;
    logic [BW-1:0] ctl_rdata;
    logic          ctl_we, byte_we, step_en;
    logic [AW-1:0] ptr [NP];

    assign ctl_we  = reg_we && (reg_waddr == RA_CTL);
    assign byte_we = reg_we && (reg_waddr != RA_CTL);
    assign step_en = acc_stb && !reg_we;

    dptr_ctrl #(.BW(BW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (reg_wdata),
        .acc_go    (step_en),
        .sel       (sel),
        .mode_pri  (mode_pri),
        .mode_shd  (mode_shd),
        .tog_en    (tog_en),
        .ctl_rdata (ctl_rdata)
    );

    for (genvar i = 0; i < NP; i++) begin : g_ptr
        dptr_bank #(.BW(BW), .NB(NB)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (int'(sel) == i),
            .wr_en   (byte_we),
            .wr_idx  (reg_waddr),
            .wr_data (reg_wdata),
            .step_en (step_en),
            .mode    ((i == 0) ? mode_pri : mode_shd),
            .ptr     (ptr[i])
        );
    end

    assign addr_out = (sel == SEL_SHD) ? ptr[1] : ptr[0];

    always_comb begin
        reg_rdata = '0;
        unique case (reg_raddr)
            RA_LO:  reg_rdata = addr_out[0*BW +: BW];
            RA_HI:  reg_rdata = addr_out[1*BW +: BW];
            RA_PG:  reg_rdata = addr_out[2*BW +: BW];
            RA_CTL: reg_rdata = ctl_rdata;
        endcase
    end

    // R10
    wr_blocks_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_waddr == RA_CTL) |=> $stable(ptr[0]) && $stable(ptr[1]));
    // R3
    ctl_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_raddr == RA_CTL |-> reg_rdata[BW-1:6] == '0);
    // R2
    byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_waddr == RA_LO) |=> addr_out[BW-1:0] == $past(reg_wdata));

endmodule

// File: tb/dptr_unit_test.sv
module dptr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_waddr;
    logic [7:0]  reg_wdata;
    logic [1:0]  reg_raddr;
    logic [7:0]  reg_rdata;
    logic        acc_stb;
    logic [23:0] addr_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // model
    logic [23:0] mp [2];
    logic        msel;
    logic [1:0]  mmode [2];
    logic        mtog;

    always #5 clk = ~clk;

    dptr_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .acc_stb(acc_stb), .addr_out(addr_out)
    );

    function automatic logic [7:0] ctl_byte();
        return {2'b00, mtog, mmode[1], mmode[0], msel};
    endfunction

    function automatic logic [23:0] stepped(logic [23:0] v, logic [1:0] m);
        if (m == 2'b01) return v + 24'd1;
        if (m == 2'b10) return v - 24'd1;
        return v;
    endfunction

    task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [1:0] a, string tag, logic [7:0] exp);
        reg_raddr = a;
        #1;
        chk(tag, {16'd0, reg_rdata}, {16'd0, exp});
    endtask

    // one clock: drive at negedge, model update, check at next negedge
    task automatic cyc(logic we, logic [1:0] wa, logic [7:0] wd, logic acc);
        @(negedge clk);
        reg_we = we; reg_waddr = wa; reg_wdata = wd; acc_stb = acc;
        if (we) begin
            if (wa == 2'd3) begin
                msel = wd[0]; mmode[0] = wd[2:1]; mmode[1] = wd[4:3]; mtog = wd[5];
            end else begin
                mp[msel][wa*8 +: 8] = wd;
            end
        end else if (acc) begin
            mp[msel] = stepped(mp[msel], mmode[msel]);
            if (mtog) msel = ~msel;
        end
        @(negedge clk);
        reg_we = 1'b0; acc_stb = 1'b0;
        #1;
    endtask

    task automatic set_ptr(logic [23:0] v);
        cyc(1'b1, 2'd0, v[7:0], 1'b0);
        cyc(1'b1, 2'd1, v[15:8], 1'b0);
        cyc(1'b1, 2'd2, v[23:16], 1'b0);
    endtask

    task automatic full_check(string tag);
        chk({tag, " R4 addr"}, addr_out, mp[msel]);
        rd(2'd3, {tag, " R3 ctl"}, ctl_byte());
    endtask

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_waddr = '0; reg_wdata = '0;
        reg_raddr = '0; acc_stb = 1'b0;
        mp[0] = '0; mp[1] = '0; msel = 1'b0; mmode[0] = '0; mmode[1] = '0; mtog = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 addr", addr_out, 24'd0);
        rd(2'd3, "R1 ctl", 8'h00);
        rd(2'd0, "R1 lo", 8'h00);
        rd(2'd2, "R1 pg", 8'h00);

        // R2 byte writes on primary, shadow untouched
        set_ptr(24'h123456);
        rd(2'd0, "R2 lo", 8'h56);
        rd(2'd1, "R2 hi", 8'h34);
        rd(2'd2, "R2 pg", 8'h12);
        cyc(1'b1, 2'd3, 8'h01, 1'b0);
        chk("R2 shadow untouched", addr_out, 24'd0);
        // R3 top bits read zero
        cyc(1'b1, 2'd3, 8'hFF, 1'b0);
        rd(2'd3, "R3 ctl mask", 8'h3F);

        // R5 carry into page, primary inc
        cyc(1'b1, 2'd3, 8'h02, 1'b0);
        set_ptr(24'h00FFFF);
        cyc(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R5 carry", addr_out, 24'h010000);
        // R6 borrow
        cyc(1'b1, 2'd3, 8'h04, 1'b0);
        cyc(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R6 borrow", addr_out, 24'h00FFFF);
        // R7 wrap both ways
        set_ptr(24'h000000);
        cyc(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R7 dec wrap", addr_out, 24'hFFFFFF);
        cyc(1'b1, 2'd3, 8'h02, 1'b0);
        cyc(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R7 inc wrap", addr_out, 24'h000000);
        // R8 modes 00 and 11
        set_ptr(24'hABCDEF);
        cyc(1'b1, 2'd3, 8'h06, 1'b0);
        cyc(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R8 rsvd", addr_out, 24'hABCDEF);
        cyc(1'b1, 2'd3, 8'h00, 1'b0);
        cyc(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R8 hold", addr_out, 24'hABCDEF);

        // R9/R11 toggle: primary inc, shadow dec
        cyc(1'b1, 2'd3, 8'h11, 1'b0);
        set_ptr(24'h010000);
        cyc(1'b1, 2'd3, 8'h32, 1'b0);
        set_ptr(24'hFFFFFF);
        cyc(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R9 swap to shadow", addr_out, 24'h010000);
        rd(2'd3, "R9 sel", 8'h33);
        cyc(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R9 back to primary", addr_out, 24'h000000);
        cyc(1'b1, 2'd3, 8'h13, 1'b0);
        chk("R11 shadow after one step", addr_out, 24'h00FFFF);

        // R10 write blocks access
        cyc(1'b1, 2'd3, 8'h32, 1'b0);
        cyc(1'b1, 2'd1, 8'h77, 1'b1);
        chk("R10 no step", addr_out, 24'h007700);
        rd(2'd3, "R10 no toggle", 8'h32);

        // random phase
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom();
            if (r[3:0] == 4'd0)
                cyc(1'b1, 2'd3, {2'b00, r[13:8]}, r[4]);
            else if (r[3:2] == 2'b01)
                cyc(1'b1, 2'(r[5:4] % 3), r[15:8], r[16]);
            else
                cyc(1'b0, 2'd0, 8'h00, r[16] | r[17]);
            full_check("rand R5/R6/R9/R10/R11");
            rd(2'(r[19:18] % 3), "rand R2 byte", mp[msel][int'(r[19:18] % 3)*8 +: 8]);
        end

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule